// File: doc/BRIEF.md
# Outer Cache Controller Register Stub

This block gives software the programming view of an outer-level cache controller while holding no tags and no data. It sits behind a 32-bit APB-style slave port and answers inside a 4 KiB window. The window holds an identity word, a cache-type word, a one-bit enable, an auxiliary configuration word, two latency words and a pair of address-filter bounds. All of these are storage only: nothing in the block acts on them.

Boot code that expects a real controller can use the stub unchanged. It can read the identity, program latencies and filters, and poll maintenance registers. Every maintenance poll reads back as finished. Accesses to offsets that the map does not list pulse an error strobe, so an integrator can count stray accesses.

The cache-type word is a build-time constant with a read side effect. Each read takes way-size and associativity bits from the auxiliary word and ORs them into the stored type value. Bits can only accumulate, and reset does not clear them.

Top module: `l2cache_stub_regs`

## Requirements
- R1: Only address bits 11:0 select a register; any values in the higher address bits alias to the same register.
- R2: A read at offset 0x000 returns 32'h410000C8. A write there is an unknown access (see R9).
- R3: A read at offset 0x004 builds a 5-bit code `k`. Bits 4:2 of `k` are auxiliary bits 19:17, bit 1 is zero and bit 0 is auxiliary bit 16. The read ORs `(k<<18)|(k<<6)` into the stored type value, stores the result and returns it. The stored value starts at the parameter `TYPE_INIT` (default 32'h1C100100), and reset does not change it. Writes to 0x004 are unknown accesses (see R9).
- R4: A write to offset 0x100 stores only bit 0 and clears bits 31:1. A read returns the stored value.
- R5: Offsets 0x104 (auxiliary), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter low bound) and 0xC04 (filter high bound) are full 32-bit read/write registers.
- R6: Reset puts 32'h02020000 in the auxiliary register and zero in the control, latency and filter registers.
- R7: Offsets 0x730 through 0x7FF read as zero, discard writes and never raise `badAccess`.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read as zero, discard writes and never raise `badAccess`.
- R9: Any other offset reads as zero, changes no state and raises `badAccess` for exactly the access cycle.
- R10: A transfer takes effect in its access cycle (`psel` and `penable` high) with no wait states. `prdata` is zero outside read access cycles. The cache-type update happens only on a read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase of the transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits 11:0 decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the read access cycle |
| badAccess | output | 1 | High during an access cycle that hits an unmapped offset |

## Verification
The assertions assume that the bus follows the two-phase protocol: `penable` is only high while `psel` is high, and address, direction and write data stay stable across setup and access. The stimulus drives every transfer as one setup cycle followed by one access cycle, and idles `psel` between transfers, so no access cycle is ever repeated. The random addresses include mapped offsets, the edges of the maintenance window and arbitrary high bits. A mid-run reset checks that the accumulated type value survives reset.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

  localparam int WORD_W = 32;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_ID      = 12'h000;
  localparam logic [OFS_W-1:0] OFS_TYPE    = 12'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 12'h100;
  localparam logic [OFS_W-1:0] OFS_AUX     = 12'h104;
  localparam logic [OFS_W-1:0] OFS_TAGLAT  = 12'h108;
  localparam logic [OFS_W-1:0] OFS_DATLAT  = 12'h10C;
  localparam logic [OFS_W-1:0] OFS_FLT_LO  = 12'hC00;
  localparam logic [OFS_W-1:0] OFS_FLT_HI  = 12'hC04;
  localparam logic [OFS_W-1:0] OFS_QUIET0  = 12'hF40;
  localparam logic [OFS_W-1:0] OFS_QUIET1  = 12'hF60;
  localparam logic [OFS_W-1:0] OFS_QUIET2  = 12'hF80;
  localparam logic [OFS_W-1:0] MAINT_FIRST = 12'h730;
  localparam logic [OFS_W-1:0] MAINT_LAST  = 12'h7FF;

  // number of plain read/write words kept in the datapath
  localparam int NUM_PLAIN = 5;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_TYPE,
    SEL_CTRL,
    SEL_AUX,
    SEL_TAGLAT,
    SEL_DATLAT,
    SEL_FLT_LO,
    SEL_FLT_HI,
    SEL_ZERO
  } regSel_e;

  // strobes from decode control to the register datapath
  typedef struct packed {
    logic    rdEn;
    logic    wrEn;
    regSel_e sel;
    logic    bad;
  } busStrobe_t;

  function automatic regSel_e plainSel(input int idx);
    case (idx)
      0:       return SEL_AUX;
      1:       return SEL_TAGLAT;
      2:       return SEL_DATLAT;
      3:       return SEL_FLT_LO;
      default: return SEL_FLT_HI;
    endcase
  endfunction

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
  import l2stub_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output busStrobe_t        stb
);

  logic             accessCyc;
  logic [OFS_W-1:0] offset;
  logic             inMaint;
  regSel_e          hitSel;
  logic             readOnlyHit;
  logic             unmapped;

  assign accessCyc = psel & penable;
  assign offset    = paddr[OFS_W-1:0];
  assign inMaint   = (offset >= MAINT_FIRST) && (offset <= MAINT_LAST);

  always_comb begin
    hitSel = SEL_NONE;
    if (inMaint) begin
      hitSel = SEL_ZERO;
    end else begin
      case (offset)
        OFS_ID:     hitSel = SEL_ID;
        OFS_TYPE:   hitSel = SEL_TYPE;
        OFS_CTRL:   hitSel = SEL_CTRL;
        OFS_AUX:    hitSel = SEL_AUX;
        OFS_TAGLAT: hitSel = SEL_TAGLAT;
        OFS_DATLAT: hitSel = SEL_DATLAT;
        OFS_FLT_LO: hitSel = SEL_FLT_LO;
        OFS_FLT_HI: hitSel = SEL_FLT_HI;
        OFS_QUIET0,
        OFS_QUIET1,
        OFS_QUIET2: hitSel = SEL_ZERO;
        default:    hitSel = SEL_NONE;
      endcase
    end
  end

  // identity and type words have no write side; a write there is stray
  assign readOnlyHit = pwrite && ((hitSel == SEL_ID) || (hitSel == SEL_TYPE));
  assign unmapped    = (hitSel == SEL_NONE) || readOnlyHit;

  always_comb begin
    stb.rdEn = accessCyc & ~pwrite;
    stb.wrEn = accessCyc & pwrite;
    stb.sel  = unmapped ? SEL_NONE : hitSel;
    stb.bad  = accessCyc & unmapped;
  end

endmodule

// File: rtl/l2stub_datapath.sv
module l2stub_datapath
  import l2stub_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE   = 32'h410000C8,
  parameter logic [WORD_W-1:0] TYPE_INIT  = 32'h1C100100,
  parameter logic [WORD_W-1:0] AUX_RESET  = 32'h02020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int K_W        = 5;
  localparam int K_HI_SHIFT = 18;
  localparam int K_LO_SHIFT = 6;

  logic [WORD_W-1:0] plainQ [NUM_PLAIN];
  logic              ctrlQ;
  logic [WORD_W-1:0] typeQ = TYPE_INIT;
  logic [K_W-1:0]    sizeCode;
  logic [WORD_W-1:0] typeMix;
  logic [WORD_W-1:0] typeNext;
  logic [WORD_W-1:0] muxOut;

  function automatic logic [WORD_W-1:0] plainReset(input int idx);
    return (idx == 0) ? AUX_RESET : '0;
  endfunction

  // plain read/write words: aux, tag latency, data latency, filter bounds
  for (genvar gi = 0; gi < NUM_PLAIN; gi++) begin : gPlain
    always_ff @(posedge clk) begin
      if (!rstN) begin
        plainQ[gi] <= plainReset(gi);
      end else if (stb.wrEn && (stb.sel == plainSel(gi))) begin
        plainQ[gi] <= pwdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= 1'b0;
    end else if (stb.wrEn && (stb.sel == SEL_CTRL)) begin
      ctrlQ <= pwdata[0];
    end
  end

  // way-size and associativity code taken from the aux word (index 0)
  assign sizeCode = {plainQ[0][19:17], 1'b0, plainQ[0][16]};
  assign typeMix  = (WORD_W'(sizeCode) << K_HI_SHIFT) |
                    (WORD_W'(sizeCode) << K_LO_SHIFT);
  assign typeNext = typeQ | typeMix;

  // type word: no reset, bits only accumulate on reads
  always_ff @(posedge clk) begin
    if (stb.rdEn && (stb.sel == SEL_TYPE)) begin
      typeQ <= typeNext;
    end
  end

  always_comb begin
    case (stb.sel)
      SEL_ID:     muxOut = ID_VALUE;
      SEL_TYPE:   muxOut = typeNext;
      SEL_CTRL:   muxOut = {{(WORD_W-1){1'b0}}, ctrlQ};
      SEL_AUX:    muxOut = plainQ[0];
      SEL_TAGLAT: muxOut = plainQ[1];
      SEL_DATLAT: muxOut = plainQ[2];
      SEL_FLT_LO: muxOut = plainQ[3];
      SEL_FLT_HI: muxOut = plainQ[4];
      default:    muxOut = '0;
    endcase
  end

  assign rdata = stb.rdEn ? muxOut : '0;

endmodule

// File: rtl/l2cache_stub_regs.sv
module l2cache_stub_regs
  import l2stub_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] ID_VALUE  = 32'h410000C8,
  parameter logic [31:0] TYPE_INIT = 32'h1C100100,
  parameter logic [31:0] AUX_RESET = 32'h02020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              badAccess
);

  busStrobe_t stb;

  l2stub_decode #(.ADDR_W(ADDR_W)) uDecode (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .stb     (stb)
  );

  l2stub_datapath #(
    .ID_VALUE  (ID_VALUE),
    .TYPE_INIT (TYPE_INIT),
    .AUX_RESET (AUX_RESET)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .pwdata (pwdata),
    .rdata  (prdata)
  );

  assign badAccess = stb.bad;

endmodule

// File: rtl/l2stub_checker.sv
module l2stub_checker #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h410000C8
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              badAccess
);

  logic        acc;
  logic        rd;
  logic [11:0] ofs;
  logic        maint;
  logic        quiet;
  logic        typeRd;
  logic        seenType;
  logic [31:0] lastType;

  assign acc    = psel && penable;
  assign rd     = acc && !pwrite;
  assign ofs    = paddr[11:0];
  assign maint  = (ofs >= 12'h730) && (ofs <= 12'h7FF);
  assign quiet  = (ofs == 12'hF40) || (ofs == 12'hF60) || (ofs == 12'hF80);
  assign typeRd = rd && (ofs == 12'h004);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenType <= 1'b0;
    end else if (typeRd) begin
      seenType <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (typeRd) lastType <= prdata;
  end

  assert_id_const_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rd && ofs == 12'h000) |-> (prdata == ID_VALUE));

  assert_type_grows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (typeRd && seenType) |-> ((prdata & lastType) == lastType));

  assert_ctrl_onebit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rd && ofs == 12'h100) |-> (prdata[31:1] == 31'd0));

  assert_maint_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acc && maint) |-> (!badAccess && prdata == 32'd0));

  assert_quiet_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (acc && quiet) |-> (!badAccess && prdata == 32'd0));

  assert_bad_in_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |-> (acc && prdata == 32'd0));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rd |-> (prdata == 32'd0));

endmodule

bind l2cache_stub_regs l2stub_checker #(
  .ADDR_W   (ADDR_W),
  .ID_VALUE (ID_VALUE)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .badAccess (badAccess)
);

// File: tb/tb_l2cache_stub_regs.sv
`timescale 1ns/1ps
module tb_l2cache_stub_regs;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              psel = 1'b0;
  logic              penable = 1'b0;
  logic              pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              badAccess;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  logic        mCtrl;
  logic [31:0] mAux, mTag, mDat, mLo, mHi;
  logic [31:0] mType = 32'h1C100100;

  always #10 clk = ~clk;

  l2cache_stub_regs #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .badAccess(badAccess)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit isMaint(input logic [11:0] o);
    return (o >= 12'h730) && (o <= 12'h7FF);
  endfunction

  function automatic bit isQuiet(input logic [11:0] o);
    return (o == 12'hF40) || (o == 12'hF60) || (o == 12'hF80);
  endfunction

  function automatic bit isRw(input logic [11:0] o);
    return (o == 12'h100) || (o == 12'h104) || (o == 12'h108) ||
           (o == 12'h10C) || (o == 12'hC00) || (o == 12'hC04);
  endfunction

  function automatic bit expBad(input logic [11:0] o, input bit wr);
    if (isMaint(o) || isQuiet(o) || isRw(o)) return 1'b0;
    if (o == 12'h000 || o == 12'h004) return wr;
    return 1'b1;
  endfunction

  function automatic logic [31:0] typeMix(input logic [31:0] aux);
    logic [31:0] k;
    k = {27'd0, aux[19:17], 1'b0, aux[16]};
    return (k << 18) | (k << 6);
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] o);
    case (o)
      12'h000: return 32'h410000C8;
      12'h004: return mType | typeMix(mAux);
      12'h100: return {31'd0, mCtrl};
      12'h104: return mAux;
      12'h108: return mTag;
      12'h10C: return mDat;
      12'hC00: return mLo;
      12'hC04: return mHi;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [11:0] o);
    if (isMaint(o)) return "R7";
    if (isQuiet(o)) return "R8";
    if (o == 12'h000) return "R2";
    if (o == 12'h004) return "R3";
    if (o == 12'h100) return "R4";
    if (isRw(o)) return "R5";
    return "R9";
  endfunction

  task automatic modelReset();
    mCtrl = 1'b0; mAux = 32'h02020000; mTag = '0; mDat = '0; mLo = '0; mHi = '0;
  endtask

  task automatic modelWrite(input logic [11:0] o, input logic [31:0] d);
    case (o)
      12'h100: mCtrl = d[0];
      12'h104: mAux = d;
      12'h108: mTag = d;
      12'h10C: mDat = d;
      12'hC00: mLo = d;
      12'hC04: mHi = d;
      default: ;
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // one setup cycle and one access cycle; checks read data and error strobe
  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [31:0] d);
    logic [11:0] o;
    logic [31:0] exp;
    bit          eb;
    o = a[11:0];
    exp = wr ? 32'd0 : expRead(o);
    eb = expBad(o, wr);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    #5;
    check(badAccess == 1'b0 && prdata == 32'd0, "R10 setup", prdata, 32'd0);
    @(negedge clk);
    penable = 1'b1;
    #5;
    check(prdata == exp, reqOf(o), prdata, exp);
    check(badAccess == eb, {reqOf(o), " bad"}, {31'd0, badAccess}, {31'd0, eb});
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0;
    if (wr) modelWrite(o, d);
    else if (o == 12'h004) mType = exp;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  localparam logic [11:0] PICKS [16] = '{
    12'h000, 12'h004, 12'h100, 12'h104, 12'h108, 12'h10C, 12'hC00, 12'hC04,
    12'hF40, 12'hF60, 12'hF80, 12'h730, 12'h7FF, 12'h72C, 12'h800, 12'h008};

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240607));
    doReset();

    // R6 reset state
    xfer(0, 32'h104, 0);
    xfer(0, 32'h100, 0);
    xfer(0, 32'h108, 0);
    xfer(0, 32'hC04, 0);
    // R2 identity, R1 alias
    xfer(0, 32'h0000_0000, 0);
    xfer(0, 32'hABCD_E000, 0);
    // R3 default type unchanged by reset aux
    xfer(0, 32'h004, 0);
    // R4 only bit 0 kept
    xfer(1, 32'h100, 32'hFFFF_FFFF);
    xfer(0, 32'h100, 0);
    xfer(1, 32'h5000_0100, 32'hFFFF_FFFE);
    xfer(0, 32'h100, 0);
    // R5 full words, alias writes
    xfer(1, 32'h108, 32'hDEAD_BEEF);
    xfer(1, 32'h1234_510C, 32'h0BAD_F00D);
    xfer(1, 32'hC00, 32'h8000_0001);
    xfer(1, 32'hC04, 32'h7FFF_FFFE);
    xfer(0, 32'h108, 0);
    xfer(0, 32'h10C, 0);
    xfer(0, 32'hC00, 0);
    xfer(0, 32'hFFFF_FC04, 0);
    // R7 window edges, writes discarded
    xfer(1, 32'h730, 32'hFFFF_FFFF);
    xfer(1, 32'h7FF, 32'h1111_1111);
    xfer(0, 32'h730, 0);
    xfer(0, 32'h7FF, 0);
    xfer(0, 32'h72F, 0);
    xfer(0, 32'h800, 0);
    // R8 quiet offsets
    xfer(1, 32'hF40, 32'h1);
    xfer(0, 32'hF60, 0);
    xfer(0, 32'hF80, 0);
    // R9 writes to read-only words are stray, state intact
    xfer(1, 32'h000, 32'h0);
    xfer(1, 32'h004, 32'hFFFF_FFFF);
    xfer(0, 32'h004, 0);
    xfer(1, 32'h110, 32'h55);
    xfer(0, 32'h108, 0);
    // R9 one-cycle strobe: idle after a stray access
    @(negedge clk); #5;
    check(badAccess == 1'b0 && prdata == 32'd0, "R9 idle", {31'd0, badAccess}, 32'd0);
    // R3 accumulation then R3 survives reset
    xfer(1, 32'h104, 32'h000F_0000);
    xfer(0, 32'h004, 0);
    xfer(1, 32'h104, 32'h0);
    xfer(0, 32'h004, 0);
    doReset();
    xfer(0, 32'h104, 0);
    xfer(0, 32'h004, 0);
    check(mType == 32'h1C74_0740, "R3 model", mType, 32'h1C74_0740);
    // R10 type unchanged by idle cycles and writes
    repeat (3) @(negedge clk);
    xfer(0, 32'h004, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      bit wr;
      wr = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) a = $urandom;
      else a = {$urandom_range(0, 15) == 0 ? 20'($urandom) : 20'd0,
                PICKS[$urandom_range(0, 15)]};
      xfer(wr, a, $urandom);
    end
    finishRun();
  end

endmodule